// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial host bus (I2C-style: clock input only, open-drain data line with an external pull-up). It gives a host processor byte-wide access to a small bank of read/write control registers, a few read-only status locations, a clear-on-read event register and two byte-stream ports. The host first sends the device address and a register pointer. It then either keeps writing data bytes, or issues a repeated START with the read address and clocks bytes out. The master NACKs the last byte it wants.

Two strap inputs fill two bits of an otherwise fixed 7-bit device address, so two or more copies can share one bus. During a burst on an ordinary register the pointer advances after every byte. On a stream port it stays put, so repeated bytes go to, or come from, the stream. A command register at pointer 0x02 turns its set bits into one-cycle pulses and never stores them. One of those pulses also returns the control bank to its reset values.

Both bus lines pass through a synchronizer inside the block. All protocol decisions are taken on SCL edges seen in the system clock domain, so the system clock must be several times faster than SCL.

Top module: `i2c_regport`

## Requirements
- R1: The device address is {0, strap_a2_i, 0, strap_a1_i, 0, 0, 0} followed by the R/W bit in the LSB. A matching address byte is ACKed (SDA pulled low in the ninth clock). A non-matching one is not ACKed, and the rest of the transaction has no effect.
- R2: In a write transaction the byte after the address is taken as the register pointer. Every following data byte is ACKed and written at the pointer.
- R3: After a repeated START with R/W=1, the slave returns the addressed register MSB first, one byte per ACK from the master. After the master's NACK, and after any STOP, the slave releases SDA.
- R4: In a burst on any pointer other than the two stream ports (0x20, 0x41), the pointer increments by one after each byte, in both directions.
- R5: Each byte written at pointer 0x20 appears on sout_data_o with sout_valid_o high for exactly one clock. The pointer stays at 0x20.
- R6: Each byte read at pointer 0x41 is the current sin_data_i, and sin_pop_o pulses for one clock to take it. The pointer stays at 0x41. When sin_valid_i is low the byte read is 0x00 and no pop is issued.
- R7: Pointers 0x00 to 0x0F (except 0x02) are read/write control registers, presented on ctrl_o with register n at bits [8n+7:8n]. After reset register 0x00 holds 0xFF and all others hold 0x00.
- R8: A write to any pointer that is not a control register, not 0x02 and not 0x20 is ACKed and discarded. Pointer 0x31 reads stat_i. Unmapped pointers read 0x00.
- R9: Writing pointer 0x02 pulses cmd_o[2], cmd_o[1] and cmd_o[0] for one clock from data bits 4, 1 and 0. Pointer 0x02 always reads 0x00. Bit 4 also returns every control register to its reset value.
- R10: Pointer 0x30 holds an event bit for each evt_i line, read as bits [4:0]. A bit is set by a one-clock pulse, stays set until that pointer is read, and is cleared by the read.
- R11: irq_o is high when some event bit is set whose mask bit (register 0x00, same bit position, 1 = masked) is 0. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_a1_i | input | 1 | Device address strap, address byte bit 4 |
| strap_a2_i | input | 1 | Device address strap, address byte bit 6 |
| evt_i | input | EVT_W | One-clock event pulses |
| stat_i | input | 8 | Read-only status byte at pointer 0x31 |
| sin_data_i | input | 8 | Head byte of the inbound stream |
| sin_valid_i | input | 1 | Inbound stream has a byte |
| sin_pop_o | output | 1 | Take the head byte of the inbound stream |
| sout_data_o | output | 8 | Outbound stream byte |
| sout_valid_o | output | 1 | Outbound byte strobe |
| ctrl_o | output | NUM_CTRL*8 | Control register contents |
| cmd_o | output | 3 | Command pulses (all-reset, unit B, unit A) |
| irq_o | output | 1 | Unmasked event pending |

## Verification
A corrupted register pointer shows in the very next byte: a burst readback returns a neighbouring register, a stream byte goes missing, or a control byte lands at the wrong place in ctrl_o. The per-clock comparison of ctrl_o catches the last case as soon as the bus goes quiet. A wrong bit counter or protocol state shows within one byte as a missing or misplaced ACK, or as a shifted readback value. Stale event bits or mask bits show on irq_o within two clocks of the event or the mask write, and in the value read back from 0x30.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
  } bus_st_t;
  localparam int PTR_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sda,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start,
  input  logic             stop,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rd_byte,
  input  logic             ptr_hold,
  output logic             sda_low,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic [PTR_W-1:0] ptr,
  output logic [7:0]       wr_data
);
  bus_st_t    st, nxt;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      mack <= 1'b0; sda_low <= 1'b0; wr_stb <= 1'b0; rd_stb <= 1'b0;
      ptr <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      // pointer moves on the clock after an access, unless it names a stream port
      if ((wr_stb || rd_stb) && !ptr_hold) ptr <= ptr + 1'b1;
      if (start) begin
        st <= ST_ADDR; cnt <= '0; sda_low <= 1'b0;
      end else if (stop) begin
        st <= ST_IDLE; sda_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG, ST_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end
            if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == dev_addr) begin
                  sda_low <= 1'b1; st <= ST_ACK;
                  nxt <= sh[0] ? ST_RDAT : ST_REG;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                if (st == ST_REG) ptr <= sh;
                else begin wr_stb <= 1'b1; wr_data <= sh; end
                sda_low <= 1'b1; st <= ST_ACK; nxt <= ST_WDAT;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0;
            if (nxt == ST_RDAT) begin
              tx <= rd_byte; sda_low <= ~rd_byte[7]; rd_stb <= 1'b1; st <= ST_RDAT;
            end else begin
              sda_low <= 1'b0; st <= nxt;
            end
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_low <= 1'b0; st <= ST_RACK;
            end else begin
              cnt <= cnt + 4'd1;
              tx <= {tx[6:0], 1'b0};
              sda_low <= ~tx[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda;
            if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx <= rd_byte; sda_low <= ~rd_byte[7]; rd_stb <= 1'b1; st <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_CTRL  = 16,
  parameter int         EVT_W     = 5,
  parameter logic [7:0] MASK_RST  = 8'hFF,
  parameter logic [7:0] MASK_ADDR = 8'h00,
  parameter logic [7:0] CMD_ADDR  = 8'h02,
  parameter logic [7:0] IST_ADDR  = 8'h30,
  parameter logic [7:0] STAT_ADDR = 8'h31,
  parameter logic [7:0] SOUT_ADDR = 8'h20,
  parameter logic [7:0] SIN_ADDR  = 8'h41
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  input  logic [PTR_W-1:0]      addr,
  input  logic [7:0]            wr_data,
  input  logic [EVT_W-1:0]      evt_i,
  input  logic [7:0]            stat_i,
  input  logic [7:0]            sin_data_i,
  input  logic                  sin_valid_i,
  output logic [7:0]            rd_byte,
  output logic                  ptr_hold,
  output logic [NUM_CTRL*8-1:0] ctrl_o,
  output logic [2:0]            cmd_o,
  output logic [7:0]            sout_data_o,
  output logic                  sout_valid_o,
  output logic                  sin_pop_o,
  output logic                  irq_o,
  output logic [EVT_W-1:0]      ist_o
);
  localparam int CA_W = $clog2(NUM_CTRL);
  localparam logic [CA_W-1:0] MASK_IDX = MASK_ADDR[CA_W-1:0];

  logic [7:0]       creg [NUM_CTRL];
  logic [EVT_W-1:0] ist;
  logic             in_ctrl;

  assign in_ctrl  = addr < 8'(NUM_CTRL);
  assign ptr_hold = (addr == SOUT_ADDR) || (addr == SIN_ADDR);
  assign ist_o    = ist;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CTRL; i++) creg[i] <= (i == int'(MASK_ADDR)) ? MASK_RST : 8'h00;
      ist <= '0; irq_o <= 1'b0; cmd_o <= '0;
      sout_data_o <= '0; sout_valid_o <= 1'b0; sin_pop_o <= 1'b0;
    end else begin
      cmd_o        <= '0;
      sout_valid_o <= 1'b0;
      sin_pop_o    <= 1'b0;
      ist   <= ist | evt_i;
      irq_o <= |(ist & ~creg[MASK_IDX][EVT_W-1:0]);
      if (wr_stb) begin
        if (addr == CMD_ADDR) begin
          cmd_o <= {wr_data[4], wr_data[1], wr_data[0]};
          if (wr_data[4])
            for (int i = 0; i < NUM_CTRL; i++) creg[i] <= (i == int'(MASK_ADDR)) ? MASK_RST : 8'h00;
        end else if (addr == SOUT_ADDR) begin
          sout_data_o  <= wr_data;
          sout_valid_o <= 1'b1;
        end else if (in_ctrl) begin
          creg[addr[CA_W-1:0]] <= wr_data;
        end
      end
      if (rd_stb) begin
        if (addr == IST_ADDR) ist <= evt_i;
        if (addr == SIN_ADDR && sin_valid_i) sin_pop_o <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (in_ctrl)                               rd_byte = creg[addr[CA_W-1:0]];
    else if (addr == IST_ADDR)                 rd_byte = 8'(ist);
    else if (addr == STAT_ADDR)                rd_byte = stat_i;
    else if (addr == SIN_ADDR && sin_valid_i)  rd_byte = sin_data_i;
  end

  generate
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_flat
      assign ctrl_o[g*8 +: 8] = creg[g];
    end
  endgenerate
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_CTRL    = 16,
  parameter int         EVT_W       = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MASK_RST    = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  strap_a1_i,
  input  logic                  strap_a2_i,
  input  logic [EVT_W-1:0]      evt_i,
  input  logic [7:0]            stat_i,
  input  logic [7:0]            sin_data_i,
  input  logic                  sin_valid_i,
  output logic                  sin_pop_o,
  output logic [7:0]            sout_data_o,
  output logic                  sout_valid_o,
  output logic [NUM_CTRL*8-1:0] ctrl_o,
  output logic [2:0]            cmd_o,
  output logic                  irq_o
);
  logic             sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic             wr_w, rd_w, hold_w;
  logic [PTR_W-1:0] ptr_w;
  logic [7:0]       wdat_w, rbyte_w;
  logic [EVT_W-1:0] ist_w;
  logic [6:0]       dev_addr;

  assign dev_addr = {1'b0, strap_a2_i, 1'b0, strap_a1_i, 3'b000};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w), .start_o(start_w), .stop_o(stop_w)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst(rst), .sda(sda_s), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start(start_w), .stop(stop_w), .dev_addr(dev_addr), .rd_byte(rbyte_w),
    .ptr_hold(hold_w), .sda_low(sda_oe_o), .wr_stb(wr_w), .rd_stb(rd_w),
    .ptr(ptr_w), .wr_data(wdat_w)
  );

  i2c_reg_bank #(.NUM_CTRL(NUM_CTRL), .EVT_W(EVT_W), .MASK_RST(MASK_RST)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_w), .rd_stb(rd_w), .addr(ptr_w), .wr_data(wdat_w),
    .evt_i(evt_i), .stat_i(stat_i), .sin_data_i(sin_data_i), .sin_valid_i(sin_valid_i),
    .rd_byte(rbyte_w), .ptr_hold(hold_w), .ctrl_o(ctrl_o), .cmd_o(cmd_o),
    .sout_data_o(sout_data_o), .sout_valid_o(sout_valid_o), .sin_pop_o(sin_pop_o),
    .irq_o(irq_o), .ist_o(ist_w)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int         EVT_W    = 5,
  parameter logic [7:0] MASK_RST = 8'hFF
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             stop_det,
  input logic             rd_stb,
  input logic [EVT_W-1:0] ist,
  input logic             irq,
  input logic [2:0]       cmd,
  input logic [7:0]       mask_byte,
  input logic             sin_pop,
  input logic             sout_valid
);
  // R3: the data line is let go after a STOP
  p_release_on_stop_r3: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R5: outbound strobe lasts one clock
  p_sout_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sout_valid |=> !sout_valid);
  // R6: pop lasts one clock
  p_pop_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sin_pop |=> !sin_pop);
  // R9: command pulses are one clock wide
  p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd != 3'b000) |=> (cmd == 3'b000));
  // R9: the all-reset pulse comes with the mask back at its reset value
  p_cmd_restore_r9: assert property (@(posedge clk) disable iff (rst)
    cmd[2] |-> (mask_byte == MASK_RST));
  // R10: event bits only drop after a read
  p_ist_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((ist & $past(ist)) == $past(ist)));
  // R11: no request without a pending event
  p_irq_needs_event_r11: assert property (@(posedge clk) disable iff (rst)
    (ist == '0) |=> !irq);
endmodule

bind i2c_regport i2c_regport_chk #(.EVT_W(EVT_W), .MASK_RST(MASK_RST)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .stop_det(stop_w), .rd_stb(rd_w),
  .ist(ist_w), .irq(irq_o), .cmd(cmd_o), .mask_byte(ctrl_o[7:0]),
  .sin_pop(sin_pop_o), .sout_valid(sout_valid_o)
);

// File: tb/sim_i2c_regport.sv
`timescale 1ns/1ps
module sim_i2c_regport;
  localparam int NC = 16;
  localparam int Q  = 8;
  localparam logic [7:0] DEV_W = 8'h10;
  localparam logic [7:0] DEV_R = 8'h11;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o;
  wire  sda_bus = sda_m & ~sda_oe_o;
  logic [4:0] evt = '0;
  logic [7:0] stat = 8'h5A;
  logic [7:0] sin_d = '0;
  logic sin_v = 1'b0;
  logic sin_pop_o, sout_valid_o, irq_o;
  logic [7:0] sout_data_o;
  logic [NC*8-1:0] ctrl_o;
  logic [2:0] cmd_o;

  i2c_regport u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe_o),
    .strap_a1_i(1'b1), .strap_a2_i(1'b0), .evt_i(evt), .stat_i(stat),
    .sin_data_i(sin_d), .sin_valid_i(sin_v), .sin_pop_o(sin_pop_o),
    .sout_data_o(sout_data_o), .sout_valid_o(sout_valid_o), .ctrl_o(ctrl_o),
    .cmd_o(cmd_o), .irq_o(irq_o)
  );

  int vectors = 0, errs = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] m_ctrl [NC];
  logic [4:0] m_ist = '0;
  logic [2:0] seen_cmd = '0;
  logic [7:0] sinq [$];
  logic [7:0] soutq [$];
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  function automatic logic [NC*8-1:0] mflat();
    logic [NC*8-1:0] r;
    for (int i = 0; i < NC; i++) r[i*8 +: 8] = m_ctrl[i];
    return r;
  endfunction

  function automatic logic m_irq();
    return |(m_ist & ~m_ctrl[0][4:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is quiet (R7, R11)
  always @(negedge clk) begin
    if (quiet && !rst) begin
      chk(ctrl_o === mflat(), "R7 ctrl_o vs model", ctrl_o, mflat());
      chk(irq_o === m_irq(), "R11 irq_o vs model", 128'(irq_o), 128'(m_irq()));
    end
    seen_cmd = seen_cmd | cmd_o;
    if (sout_valid_o) soutq.push_back(sout_data_o);
    if (sin_pop_o && sinq.size() > 0) void'(sinq.pop_front());
    sin_v = sinq.size() > 0;
    sin_d = (sinq.size() > 0) ? sinq[0] : 8'h00;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2);
    acked = !sda_bus;
    tick(Q / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q); b = {b[6:0], sda_bus}; scl_m = 1'b0;
    end
    sda_m = last; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  function automatic bit is_stream(input logic [7:0] a);
    return (a == 8'h20) || (a == 8'h41);
  endfunction

  task automatic wr_tx(input logic [7:0] dev, input logic [7:0] ra, input int n, output bit ok);
    bit a;
    logic [7:0] p;
    quiet = 1'b0;
    bstart();
    send_byte(dev, a); ok = a;
    if (a) begin
      send_byte(ra, a); ok &= a;
      for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); ok &= a; end
    end
    bstop(); tick(4);
    if (ok && dev == DEV_W) begin
      p = ra;
      for (int i = 0; i < n; i++) begin
        if (p == 8'h02) begin
          if (wbuf[i][4]) for (int k = 0; k < NC; k++) m_ctrl[k] = (k == 0) ? 8'hFF : 8'h00;
        end else if (p == 8'h20) begin
        end else if (p < 8'(NC)) m_ctrl[p[3:0]] = wbuf[i];
        if (!is_stream(p)) p = p + 8'd1;
      end
    end
    quiet = 1'b1;
  endtask

  task automatic rd_tx(input logic [7:0] ra, input int n, output bit ok);
    bit a;
    logic [7:0] p;
    quiet = 1'b0;
    bstart();
    send_byte(DEV_W, a); ok = a;
    send_byte(ra, a); ok &= a;
    bstart();
    send_byte(DEV_R, a); ok &= a;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    tick(Q);
    chk(sda_oe_o == 1'b0, "R3 SDA released after NACK", 128'(sda_oe_o), 128'(0));
    bstop(); tick(4);
    p = ra;
    for (int i = 0; i < n; i++) begin
      if (p == 8'h30) m_ist = '0;
      if (!is_stream(p)) p = p + 8'd1;
    end
    quiet = 1'b1;
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    quiet = 1'b0;
    evt = v; tick(1); evt = '0; tick(4);
    m_ist = m_ist | v;
    quiet = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired act 0 exp 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    bit ok;
    for (int k = 0; k < NC; k++) m_ctrl[k] = (k == 0) ? 8'hFF : 8'h00;
    tick(5); rst = 1'b0; tick(5);
    // R7 reset values
    chk(ctrl_o === {{(NC-1){8'h00}}, 8'hFF}, "R7 reset ctrl_o", ctrl_o, {{(NC-1){8'h00}}, 8'hFF});
    chk(!sda_oe_o && !irq_o && !sout_valid_o && !sin_pop_o, "R7 reset outputs idle",
        {sda_oe_o, irq_o, sout_valid_o, sin_pop_o}, 0);
    quiet = 1'b1;

    // R1 wrong device address: no ACK, nothing written
    wbuf[0] = 8'h77;
    wr_tx(8'h50, 8'h05, 1, ok);
    chk(!ok, "R1 foreign address not ACKed", 128'(ok), 128'(0));
    chk(ctrl_o[5*8 +: 8] == 8'h00, "R1 foreign write no effect", ctrl_o[5*8 +: 8], 0);

    // R2 / R4 burst write then burst read
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h7E;
    wr_tx(DEV_W, 8'h05, 3, ok);
    chk(ok, "R2 all write bytes ACKed", 128'(ok), 128'(1));
    chk(ctrl_o[7*8 +: 8] == 8'h7E, "R4 write pointer advanced", ctrl_o[7*8 +: 8], 8'h7E);
    rd_tx(8'h05, 3, ok);
    chk(ok, "R3 read address phase ACKed", 128'(ok), 128'(1));
    chk({rbuf[0], rbuf[1], rbuf[2]} == {m_ctrl[5], m_ctrl[6], m_ctrl[7]}, "R3 R4 burst readback",
        {rbuf[0], rbuf[1], rbuf[2]}, {m_ctrl[5], m_ctrl[6], m_ctrl[7]});

    // R8 read-only and unmapped pointers
    wbuf[0] = 8'h99;
    wr_tx(DEV_W, 8'h31, 1, ok);
    chk(ok, "R8 write to read-only ACKed", 128'(ok), 128'(1));
    rd_tx(8'h31, 1, ok);
    chk(rbuf[0] == 8'h5A, "R8 status byte unchanged", rbuf[0], 8'h5A);
    rd_tx(8'h77, 1, ok);
    chk(rbuf[0] == 8'h00, "R8 unmapped reads zero", rbuf[0], 0);

    // R10 / R11 events, mask, clear on read
    pulse_evt(5'b00101);
    chk(irq_o == 1'b0, "R11 all masked after reset", 128'(irq_o), 0);
    wbuf[0] = 8'h1C;
    wr_tx(DEV_W, 8'h00, 1, ok);
    chk(irq_o == 1'b1, "R11 unmasked event raises irq", 128'(irq_o), 1);
    rd_tx(8'h30, 1, ok);
    chk(rbuf[0] == 8'h05, "R10 event bits read", rbuf[0], 8'h05);
    rd_tx(8'h30, 1, ok);
    chk(rbuf[0] == 8'h00, "R10 cleared by read", rbuf[0], 0);
    chk(irq_o == 1'b0, "R11 irq drops after clear", 128'(irq_o), 0);

    // R6 inbound stream, pointer fixed, empty reads zero
    sinq.push_back(8'h11); sinq.push_back(8'h22); sinq.push_back(8'h33);
    tick(2);
    rd_tx(8'h41, 4, ok);
    chk({rbuf[0], rbuf[1], rbuf[2], rbuf[3]} == 32'h11223300, "R6 stream bytes in order",
        {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h11223300);
    chk(sinq.size() == 0, "R6 three pops issued", sinq.size(), 0);

    // R5 outbound stream, pointer fixed
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    wr_tx(DEV_W, 8'h20, 3, ok);
    chk(soutq.size() == 3, "R5 three stream strobes", soutq.size(), 3);
    if (soutq.size() == 3)
      chk({soutq[0], soutq[1], soutq[2]} == 24'hC1C2C3, "R5 stream byte order",
          {soutq[0], soutq[1], soutq[2]}, 24'hC1C2C3);

    // R9 command pulses, reads zero, bit 4 restores defaults
    seen_cmd = '0;
    wbuf[0] = 8'h03;
    wr_tx(DEV_W, 8'h02, 1, ok);
    chk(seen_cmd == 3'b011, "R9 unit pulses", seen_cmd, 3'b011);
    rd_tx(8'h02, 1, ok);
    chk(rbuf[0] == 8'h00, "R9 command reads zero", rbuf[0], 0);
    seen_cmd = '0;
    wbuf[0] = 8'h10;
    wr_tx(DEV_W, 8'h02, 1, ok);
    chk(seen_cmd == 3'b100, "R9 all-reset pulse", seen_cmd, 3'b100);
    chk(ctrl_o === {{(NC-1){8'h00}}, 8'hFF}, "R9 controls restored", ctrl_o, {{(NC-1){8'h00}}, 8'hFF});

    tick(20);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule